// File: doc/BRIEF.md
# Piecewise-Linear Deadtime Interpolator

This block turns a sampled load-current code into a deadtime setting. It reads the value from a small table of breakpoint values and interpolates linearly between the two breakpoints that bracket the current. It is meant to be strobed once per switching period. The table is held in registers and is rewritten through a simple write port, normally by an adaptation engine. Besides the deadtime, the block reports the lower breakpoint index and the fractional weight it used, so the same engine can apportion a gradient step between the two breakpoints.

The breakpoints are not evenly spaced. `NLOW` of them sit at equal steps of `2**STEP_LG` codes starting at code 0. One more breakpoint sits far out at code `FAR_POS`. With the defaults there are six breakpoints at codes 0, 8, 16, 24, 32 and 40, and a seventh at code 200. If one code is taken as 0.5 A, these fall at 0–20 A in 4 A steps, plus 100 A. Any current at or above the far breakpoint returns the far breakpoint's value. The result is rounded to the nearest whole deadtime unit and is registered. It appears two clock cycles after the strobe.

Top module: `pwl_deadtime_lut`

## Requirements
- R1: After reset, every breakpoint value is 0, `out_vld` is 0, and `out_val`, `out_idx` and `out_frac` are 0.
- R2: A strobe on `in_vld` gives exactly one `out_vld` pulse. The pulse comes two clock cycles later, together with `out_val`, `out_idx` and `out_frac` for that sample.
- R3: For `cur_code` below the last evenly spaced breakpoint (`(NLOW-1)*2**STEP_LG`, which is 40 by default), `out_idx` is `cur_code >> STEP_LG`. `out_frac` is the remainder `cur_code mod 2**STEP_LG`, scaled to an 8-bit fraction (remainder × 256 / 2**STEP_LG).
- R4: For `cur_code` from 40 up to but not including `FAR_POS` (200), `out_idx` is `NLOW-1` (5). `out_frac` is floor((cur_code − 40) × 256 / 160), so the weight is measured against the wide span.
- R5: For `cur_code` at or above `FAR_POS`, `out_idx` is `NLOW` (6), `out_frac` is 0, and `out_val` equals breakpoint 6.
- R6: `out_val` is floor(((256 − f)·v[i] + f·v[i+1] + 128) / 256), where f is `out_frac` and i is `out_idx`. This rounds to nearest, with halves rounded up. The result never lies outside the range spanned by the two breakpoints.
- R7: When `cur_code` lies exactly on a breakpoint, `out_val` equals that breakpoint's value.
- R8: With `wr_en` high at a clock edge, breakpoint `wr_idx` takes `wr_data`. A write with `wr_idx` of 7 or more changes no breakpoint.
- R9: A lookup strobed in the same cycle as a write to one of its breakpoints uses the old value. The next lookup uses the new value.
- R10: Between results, `out_val`, `out_idx` and `out_frac` hold their last values, and `out_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Lookup strobe, once per switching period |
| cur_code | input | 8 | Sampled load-current code |
| wr_en | input | 1 | Breakpoint write enable |
| wr_idx | input | 3 | Breakpoint index to write |
| wr_data | input | 8 | New breakpoint value |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| out_val | output | 8 | Interpolated, rounded deadtime |
| out_idx | output | 3 | Lower breakpoint index used |
| out_frac | output | 8 | Weight of the upper breakpoint, in units of 1/256 |

## Verification
The bench aims at the seam between the evenly spaced segments and the wide segment, at codes 39, 40 and 41. A design that kept the narrow step there would report index 5 with a weight that wraps every 8 codes. It also drives codes 199, 200 and 255. Here a design that read past the last breakpoint, or left the weight nonzero, would return a value blended with a nonexistent entry. Exact half-weight rounding cases (0 → 1 at weight 128) catch a design that truncates. The out-of-range write and the write that lands in the same cycle as a lookup expose a decoder that aliases index 7, and a read path that bypasses the new value one cycle early.

// File: rtl/pwl_deadtime_lut.sv
module pwl_deadtime_lut #(
  parameter int CUR_W   = 8,
  parameter int DW      = 8,
  parameter int FW      = 8,
  parameter int STEP_LG = 3,
  parameter int NLOW    = 6,
  parameter int FAR_POS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [CUR_W-1:0]  cur_code,
  input  logic              wr_en,
  input  logic [$clog2(NLOW+1)-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  output logic              out_vld,
  output logic [DW-1:0]     out_val,
  output logic [$clog2(NLOW+1)-1:0] out_idx,
  output logic [FW-1:0]     out_frac
);
  localparam int NV      = NLOW + 1;
  localparam int IW      = $clog2(NV);
  localparam int LOW_END = (NLOW - 1) << STEP_LG;
  localparam int SPAN    = FAR_POS - LOW_END;
  localparam int PW      = DW + FW + 2;
  localparam logic [CUR_W-1:0] FAR_C = CUR_W'(FAR_POS);
  localparam logic [CUR_W-1:0] LOW_C = CUR_W'(LOW_END);
  localparam logic [CUR_W-1:0] MASK  = CUR_W'((1 << STEP_LG) - 1);

  logic [DW-1:0] vtx [NV];

  logic [IW-1:0]       sel_idx, nxt_idx;
  logic [FW-1:0]       sel_frac;
  logic [CUR_W-1:0]    off;
  logic [CUR_W+FW-1:0] far_num;

  logic          s1_vld;
  logic [IW-1:0] s1_idx;
  logic [FW-1:0] s1_frac;
  logic [DW-1:0] s1_lo, s1_hi;
  logic [PW-1:0] acc;

  assign off     = cur_code - LOW_C;
  assign far_num = {off, {FW{1'b0}}};

  always_comb begin
    if (cur_code >= FAR_C) begin
      sel_idx  = IW'(NV - 1);
      sel_frac = '0;
    end else if (cur_code >= LOW_C) begin
      sel_idx  = IW'(NLOW - 1);
      sel_frac = FW'(far_num / (CUR_W+FW)'(SPAN));
    end else begin
      sel_idx  = IW'(cur_code >> STEP_LG);
      sel_frac = FW'((cur_code & MASK)) << (FW - STEP_LG);
    end
  end

  assign nxt_idx = (sel_idx == IW'(NV - 1)) ? sel_idx : sel_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NV; k++) vtx[k] <= '0;
    end else if (wr_en && int'(wr_idx) < NV) begin
      vtx[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_idx  <= '0;
      s1_frac <= '0;
      s1_lo   <= '0;
      s1_hi   <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_idx  <= sel_idx;
        s1_frac <= sel_frac;
        s1_lo   <= vtx[sel_idx];
        s1_hi   <= vtx[nxt_idx];
      end
    end
  end

  assign acc = (PW'(1 << FW) - PW'(s1_frac)) * PW'(s1_lo)
             + PW'(s1_frac) * PW'(s1_hi)
             + PW'(1 << (FW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_val  <= '0;
      out_idx  <= '0;
      out_frac <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_val  <= acc[FW +: DW];
        out_idx  <= s1_idx;
        out_frac <= s1_frac;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> int'(out_idx) < NV); // R3
  AST_TOP_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_idx == IW'(NV - 1)) |-> out_frac == '0); // R5
  AST_RESULT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> ((out_val >= $past(s1_lo) || out_val >= $past(s1_hi)) &&
                (out_val <= $past(s1_lo) || out_val <= $past(s1_hi)))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> (!out_vld && $stable(out_val) && $stable(out_idx) && $stable(out_frac))); // R10
endmodule

// File: tb/test_pwl_deadtime_lut.sv
`timescale 1ns/1ps
module test_pwl_deadtime_lut;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [7:0] cur_code = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       out_vld;
  logic [7:0] out_val;
  logic [2:0] out_idx;
  logic [7:0] out_frac;

  int n_chk = 0;
  int n_bad = 0;
  int mdl [7];

  always #4 clk = ~clk;

  pwl_deadtime_lut i_pwl_deadtime_lut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cur_code(cur_code),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .out_vld(out_vld), .out_val(out_val), .out_idx(out_idx), .out_frac(out_frac));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int e_idx(int c);
    if (c >= 200) return 6;
    if (c >= 40) return 5;
    return c / 8;
  endfunction

  function automatic int e_frac(int c);
    if (c >= 200) return 0;
    if (c >= 40) return ((c - 40) * 256) / 160;
    return (c % 8) * 32;
  endfunction

  function automatic int e_val(int c);
    int i = e_idx(c);
    int f = e_frac(c);
    int j = (i == 6) ? 6 : i + 1;
    return ((256 - f) * mdl[i] + f * mdl[j] + 128) / 256;
  endfunction

  task automatic wr(int idx, int val);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 7) mdl[idx] = val;
  endtask

  task automatic look(int c, string req);
    cur_code = 8'(c); in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check({req, " vld early"}, int'(out_vld), 0);
    @(negedge clk);
    check({req, " vld"}, int'(out_vld), 1);
    check({req, " idx"}, int'(out_idx), e_idx(c));
    check({req, " frac"}, int'(out_frac), e_frac(c));
    check({req, " val"}, int'(out_val), e_val(c));
  endtask

  task automatic t_reset;
    check("R1 vld", int'(out_vld), 0);
    check("R1 val", int'(out_val), 0);
    check("R1 idx", int'(out_idx), 0);
    check("R1 frac", int'(out_frac), 0);
    look(20, "R1 table zero");
    check("R1 val zero", int'(out_val), 0);
  endtask

  task automatic t_pulse;
    look(12, "R2");
    @(negedge clk);
    check("R2 single pulse", int'(out_vld), 0);
  endtask

  task automatic t_low;
    for (int c = 0; c < 40; c += 3) look(c, "R3");
    look(39, "R3 seam");
  endtask

  task automatic t_far;
    look(40, "R4 start");
    look(41, "R4");
    look(120, "R4 mid");
    check("R4 mid frac", int'(out_frac), 128);
    look(199, "R4 end");
  endtask

  task automatic t_top;
    look(200, "R5");
    check("R5 val", int'(out_val), mdl[6]);
    look(255, "R5 max");
    check("R5 frac", int'(out_frac), 0);
  endtask

  task automatic t_round;
    wr(0, 0); wr(1, 1);
    look(4, "R6 half");
    check("R6 half up", int'(out_val), 1);
    look(3, "R6 below half");
    check("R6 down", int'(out_val), 0);
    wr(0, 255); wr(1, 255);
    look(5, "R6 full scale");
    check("R6 sat", int'(out_val), 255);
  endtask

  task automatic t_exact;
    for (int k = 0; k < 6; k++) begin
      look(k * 8, "R7");
      check("R7 on vertex", int'(out_val), mdl[k]);
    end
  endtask

  task automatic t_badwr;
    wr(7, 8'hAA);
    for (int k = 0; k < 6; k++) begin
      look(k * 8, "R8 ignored");
      check("R8 untouched", int'(out_val), mdl[k]);
    end
    look(230, "R8 top untouched");
    check("R8 top", int'(out_val), mdl[6]);
  endtask

  task automatic t_collide;
    int old = mdl[2];
    cur_code = 8'd16; in_vld = 1'b1;
    wr_en = 1'b1; wr_idx = 3'd2; wr_data = 8'd222;
    @(negedge clk);
    in_vld = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R9 old value", int'(out_val), old);
    mdl[2] = 222;
    look(16, "R9 new");
    check("R9 new value", int'(out_val), 222);
  endtask

  task automatic t_hold;
    int v, i, f;
    look(77, "R10 setup");
    v = int'(out_val); i = int'(out_idx); f = int'(out_frac);
    cur_code = 8'd3;
    repeat (5) @(negedge clk);
    check("R10 vld", int'(out_vld), 0);
    check("R10 val", int'(out_val), v);
    check("R10 idx", int'(out_idx), i);
    check("R10 frac", int'(out_frac), f);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) mdl[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    wr(0, 100); wr(1, 90); wr(2, 77); wr(3, 64);
    wr(4, 50); wr(5, 31); wr(6, 6);
    t_pulse;
    t_low;
    t_far;
    t_top;
    t_exact;
    t_badwr;
    t_collide;
    t_hold;
    t_round;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule